// File: doc/BRIEF.md
# Nine-Bit Asynchronous Serial Transmitter

This block serialises one byte plus an extra ninth bit into an eleven-bit asynchronous frame on a single output line. A host writes the byte and the ninth bit in one strobe. The block then waits for the next bit boundary of a free-running oversampling counter, which a neighbouring receiver can share. It sends the frame and raises a transmit-complete flag. The flag stays set until the host clears it.

Bit timing comes from a sixteen-state counter that advances on a sub-bit tick. At elaboration, a parameter picks where that tick comes from: every clock, every second clock, or an external timer input. The frame has no bit counter. A marker one is shifted into a zero-filled shift register, and the end of the frame is detected when the marker sits just above the ninth bit at the output.

Top module: `ser9_tx`

## Requirements
- R1: After reset, `txd` is 1, `busy` is 0 and `done` is 0. Whenever `busy` is 0, `txd` is 1.
- R2: A frame is sent in this order, each bit lasting one bit period (OVERSAMPLE sub-bit ticks): a start bit of 0, `wr_data` bit 0 through bit DATA_W-1, `wr_bit9`, then a stop bit of 1.
- R3: The start bit begins at the first counter rollover after the accepted write, so between 1 and one bit period later. Frame bit boundaries always fall at the same phase of the free-running counter, whatever the timing of the write.
- R4: `done` rises exactly 10 bit periods after the start bit begins, in the same cycle that `txd` returns to 1 for the stop bit. This is the 11th rollover after the write.
- R5: Once set, `done` stays at 1 until `done_clr` is pulsed. A pulse returns it to 0.
- R6: `busy` is 1 from the cycle after an accepted write until `done` rises. It is 0 from then on.
- R7: A write while `busy` is 1 is ignored. The frame in progress keeps its data, its ninth bit and its timing.
- R8: With RATE = RATE_DIV16, one bit lasts 16 clocks. With RATE_DIV32, it lasts 32 clocks. With RATE_EXT, it lasts 16 pulses of `ext_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_tick | input | 1 | Sub-bit tick from an external timer (used only with RATE_EXT) |
| wr_en | input | 1 | Write strobe for a new frame |
| wr_data | input | DATA_W | Data bits of the frame |
| wr_bit9 | input | 1 | Ninth bit of the frame |
| done_clr | input | 1 | Pulse to clear the transmit-complete flag |
| txd | output | 1 | Serial line, idles at 1 |
| busy | output | 1 | A frame is pending or in progress |
| done | output | 1 | Sticky transmit-complete flag |

## Verification
The assertions check on every cycle that:
- a frame only starts on a counter rollover that follows a request;
- the flag rises only as the send phase ends;
- the flag holds until it is cleared;
- the shift register does not move between rollovers while busy;
- the line is high whenever the block is idle;
- the counter stays in range.

Only the bench scenarios can show the remaining behaviour:
- the bit order on the line for every byte and ninth-bit value;
- the fixed phase of bit boundaries against randomly timed writes;
- the exact cycle at which the flag rises;
- that a write during a frame leaves the frame unchanged;
- the bit length in each of the three rate variants.

// File: rtl/ser9_pkg.sv
package ser9_pkg;
   typedef enum logic [1:0] {
      RATE_DIV16 = 2'd0,
      RATE_DIV32 = 2'd1,
      RATE_EXT   = 2'd2
   } rate_e;
endpackage

// File: rtl/ser9_tick_gen.sv
module ser9_tick_gen #(
   parameter ser9_pkg::rate_e RATE = ser9_pkg::RATE_DIV16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_tick,
   output logic tick
);
   generate
      if (RATE == ser9_pkg::RATE_DIV16) begin : g_div16
         logic unused_in;
         assign unused_in = ^{clk, rst_n, ext_tick};
         assign tick = 1'b1;
      end else if (RATE == ser9_pkg::RATE_DIV32) begin : g_div32
         logic half;
         logic unused_in;
         assign unused_in = ext_tick;
         always_ff @(posedge clk) begin
            if (!rst_n) half <= 1'b0;
            else        half <= ~half;
         end
         assign tick = half;
      end else begin : g_ext
         logic unused_in;
         assign unused_in = ^{clk, rst_n};
         assign tick = ext_tick;
      end
   endgenerate
endmodule

// File: rtl/ser9_bit_timer.sv
module ser9_bit_timer #(
   parameter int OVERSAMPLE = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output logic roll
);
   localparam int CW = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
   localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);

   generate
      if (OVERSAMPLE < 2) begin : g_bad_os
         $error("OVERSAMPLE must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
   end

   assign roll = tick && (cnt == LAST);

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);                                                    // R8
   AST_ROLL_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
      roll |=> (cnt == '0));                                           // R3
endmodule

// File: rtl/ser9_tx_core.sv
module ser9_tx_core #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              roll,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_bit9,
   input  logic              done_clr,
   output logic              txd,
   output logic              busy,
   output logic              done
);
   localparam int SR_W = DATA_W + 1;

   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("DATA_W must be at least 2");
      end
   endgenerate

   logic [SR_W-1:0] sr;
   logic            req;
   logic            send;
   logic            data_ph;
   logic            marked;
   logic            accept;
   logic            frame_end;
   logic            fin;

   assign busy      = req | send;
   assign accept    = wr_en & ~busy;
   assign frame_end = marked && sr[1] && (sr[SR_W-1:2] == '0);
   assign fin       = roll && send && data_ph && frame_end;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr      <= '0;
         req     <= 1'b0;
         send    <= 1'b0;
         data_ph <= 1'b0;
         marked  <= 1'b0;
         done    <= 1'b0;
      end else begin
         if (accept) begin
            sr  <= {wr_bit9, wr_data};
            req <= 1'b1;
         end
         if (roll) begin
            if (req && !send) begin
               send    <= 1'b1;
               req     <= 1'b0;
               data_ph <= 1'b0;
               marked  <= 1'b0;
            end else if (send && !data_ph) begin
               data_ph <= 1'b1;
            end else if (send) begin
               sr     <= {~marked, sr[SR_W-1:1]};
               marked <= 1'b1;
               if (frame_end) begin
                  send    <= 1'b0;
                  data_ph <= 1'b0;
               end
            end
         end
         if (fin)           done <= 1'b1;
         else if (done_clr) done <= 1'b0;
      end
   end

   always_comb begin
      txd = 1'b1;
      if (send) txd = data_ph ? sr[0] : 1'b0;
   end

   AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd);                                                  // R1
   AST_START_ON_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(send) |-> ($past(roll) && $past(req)));                    // R3
   AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $fell(send));                                    // R4
   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !done_clr) |=> done);                                   // R5
   AST_SR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !roll) |=> $stable(sr));                                // R7
endmodule

// File: rtl/ser9_tx.sv
module ser9_tx #(
   parameter int              DATA_W     = 8,
   parameter int              OVERSAMPLE = 16,
   parameter ser9_pkg::rate_e RATE       = ser9_pkg::RATE_DIV16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_tick,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_bit9,
   input  logic              done_clr,
   output logic              txd,
   output logic              busy,
   output logic              done
);
   logic tick;
   logic roll;

   ser9_tick_gen #(.RATE(RATE)) u_tick (
      .clk(clk), .rst_n(rst_n), .ext_tick(ext_tick), .tick(tick)
   );

   ser9_bit_timer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick), .roll(roll)
   );

   ser9_tx_core #(.DATA_W(DATA_W)) u_core (
      .clk(clk), .rst_n(rst_n), .roll(roll),
      .wr_en(wr_en), .wr_data(wr_data), .wr_bit9(wr_bit9),
      .done_clr(done_clr), .txd(txd), .busy(busy), .done(done)
   );
endmodule

// File: tb/sim_ser9_tx.sv
module sim_ser9_tx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ext_tick = 1'b0;
   logic [2:0] wr_en = '0;
   logic [2:0] clr = '0;
   logic [2:0] wb9 = '0;
   logic [7:0] wd [3];
   logic [2:0] txd_w, busy_w, done_w;
   int         cyc = 0;
   int         n_chk = 0;
   int         n_bad = 0;
   int         phase [3] = '{-1, -1, -1};
   int         blen  [3] = '{16, 32, 48};
   bit         finished = 1'b0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   initial begin
      wd[0] = '0; wd[1] = '0; wd[2] = '0;
   end

   ser9_tx #(.DATA_W(8), .OVERSAMPLE(16), .RATE(ser9_pkg::RATE_DIV16)) u0 (
      .clk(clk), .rst_n(rst_n), .ext_tick(ext_tick), .wr_en(wr_en[0]),
      .wr_data(wd[0]), .wr_bit9(wb9[0]), .done_clr(clr[0]),
      .txd(txd_w[0]), .busy(busy_w[0]), .done(done_w[0]));
   ser9_tx #(.DATA_W(8), .OVERSAMPLE(16), .RATE(ser9_pkg::RATE_DIV32)) u1 (
      .clk(clk), .rst_n(rst_n), .ext_tick(ext_tick), .wr_en(wr_en[1]),
      .wr_data(wd[1]), .wr_bit9(wb9[1]), .done_clr(clr[1]),
      .txd(txd_w[1]), .busy(busy_w[1]), .done(done_w[1]));
   ser9_tx #(.DATA_W(8), .OVERSAMPLE(16), .RATE(ser9_pkg::RATE_EXT)) u2 (
      .clk(clk), .rst_n(rst_n), .ext_tick(ext_tick), .wr_en(wr_en[2]),
      .wr_data(wd[2]), .wr_bit9(wb9[2]), .done_clr(clr[2]),
      .txd(txd_w[2]), .busy(busy_w[2]), .done(done_w[2]));

   // external tick: one pulse every third clock
   initial begin
      forever begin
         @(negedge clk); ext_tick = 1'b0;
         @(negedge clk); ext_tick = 1'b0;
         @(negedge clk); ext_tick = 1'b1;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic wait_to(input int target);
      while (cyc < target) @(negedge clk);
   endtask

   task automatic run_frame(input int k, input logic [7:0] d, input logic b9,
                            input bit poke);
      int bl, wcyc, fcyc, t;
      logic exp_bit;
      bl = blen[k];
      @(negedge clk);
      wd[k] = d; wb9[k] = b9; wr_en[k] = 1'b1; wcyc = cyc + 1;
      @(negedge clk);
      wr_en[k] = 1'b0;
      chk("R6 busy after write", busy_w[k], 1);
      t = 0;
      while (txd_w[k] !== 1'b0 && t < 4 * bl) begin
         @(negedge clk); t++;
      end
      fcyc = cyc;
      chk("R3 start within one bit", (fcyc - wcyc >= 1 && fcyc - wcyc <= bl) ? 1 : 0, 1);
      if (phase[k] < 0) phase[k] = fcyc % bl;
      chk("R3 bit phase fixed", fcyc % bl, phase[k]);
      for (int i = 0; i < 11; i++) begin
         wait_to(fcyc + i * bl + bl / 2);
         if (i == 0)       exp_bit = 1'b0;
         else if (i <= 8)  exp_bit = d[i-1];
         else if (i == 9)  exp_bit = b9;
         else              exp_bit = 1'b1;
         chk($sformatf("R2 bit %0d", i), txd_w[k], exp_bit);
         if (i <= 9) begin
            chk("R4 done low mid frame", done_w[k], 0);
            chk("R6 busy mid frame", busy_w[k], 1);
         end else begin
            chk("R6 busy clear at stop", busy_w[k], 0);
         end
         if (poke && i == 4) begin
            wd[k] = ~d; wb9[k] = ~b9; wr_en[k] = 1'b1;   // R7 ignored write
            @(negedge clk);
            wr_en[k] = 1'b0;
         end
         if (i == 9) begin
            wait_to(fcyc + 10 * bl - 1);
            chk("R4 done not early", done_w[k], 0);
            wait_to(fcyc + 10 * bl);
            chk("R4 done edge", done_w[k], 1);
            chk("R4 stop with done", txd_w[k], 1);
         end
      end
      wait_to(fcyc + 12 * bl);
      chk("R1 idle high", txd_w[k], 1);
      chk("R5 done held", done_w[k], 1);
      clr[k] = 1'b1;
      @(negedge clk);
      clr[k] = 1'b0;
      chk("R5 done cleared", done_w[k], 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int k = 0; k < 3; k++) begin
         chk("R1 reset txd", txd_w[k], 1);
         chk("R1 reset busy", busy_w[k], 0);
         chk("R1 reset done", done_w[k], 0);
      end
      // R8 / R2: full sweep on the divide-by-16 variant
      for (int v = 0; v < 512; v++) begin
         repeat ((v * 7) % 13) @(negedge clk);
         run_frame(0, v[7:0], v[8], v[2:0] == 3'd3);
      end
      // R8: other rate variants
      for (int k = 1; k < 3; k++) begin
         for (int j = 0; j < 6; j++) begin
            repeat ((j * 5) % 11) @(negedge clk);
            run_frame(k, 8'(8'h35 * j + 8'h5a), j[0], j == 2);
         end
      end
      if (!finished) begin
         finished = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule